// File: doc/BRIEF.md
# Context tag CRC8 unit

This block derives the one-byte integrity tag kept beside each connection context. A request brings a 24-bit connection identifier, a 4-bit region code, a 4-bit type code, an operation code and, when there is one, the tag already held with the context. The block packs the three identity fields into one 32-bit word and runs a CRC-8 over that word in a single parallel step. It then returns one of two things: a fresh tag with its valid mark set, or the invalidated form of the stored tag. With either result it reports whether the stored tag agrees with the fresh computation.

Requests and responses each use a valid/ready handshake. The response is registered and appears in the cycle after the request is accepted. While a response waits to be taken, no new request is accepted and the response holds its value. Region codes 2 and 4 name the two aggregation context regions. The CRC treats them like any other region value.

Top module: `ctx_tag_crc8`

## Requirements
- R1: The CRC input word is {cid[23:0], region[3:0], type[3:0]}, with the identifier in bits 31:8, the region in bits 7:4 and the type in bits 3:0.
- R2: The CRC uses generator x^8+x^2+x+1 (0x07) and starts from 0xFF. The word is shifted in MSB first: bit 31 enters first and bit 0 enters last. An all-zero word gives CRC 0xD1.
- R3: For operation code 0 (generate), the response tag is 0x80 OR the low 7 bits of the CRC.
- R4: For operation code 2 (invalidate), the response tag is the stored tag with bit 7 cleared and bits 6:0 unchanged.
- R5: Operation code 1 (check) and the reserved code 3 both return the same fresh tag as code 0.
- R6: For every operation code, the match flag is 1 only when stored tag bit 7 is 1 and stored bits 6:0 equal CRC bits 6:0.
- R7: A request accepted at a rising edge yields rsp_valid_o = 1 with its result right after that edge.
- R8: While rsp_valid_o is 1 and rsp_ready_i is 0, req_ready_o is 0 and rsp_tag_o and rsp_match_o hold their values.
- R9: During and right after reset, rsp_valid_o is 0 and req_ready_o is 1.
- R10: With rsp_ready_i held at 1, one request is accepted every cycle. A response that is taken with no new request behind it drops rsp_valid_o at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_op_i | input | 2 | 0 generate, 1 check, 2 invalidate, 3 reserved (acts as generate) |
| req_cid_i | input | 24 | Connection identifier |
| req_region_i | input | 4 | Region code |
| req_type_i | input | 4 | Type code |
| req_tag_i | input | 8 | Tag stored with the context |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response taken |
| rsp_tag_o | output | 8 | Fresh tag or invalidated stored tag |
| rsp_match_o | output | 1 | Stored tag agrees with the fresh CRC |

## Verification
The CRC mask network has no state. A wrong XOR term therefore shows up as a wrong rsp_tag_o in the cycle right after an affected request is accepted, but only for words that exercise that input bit or seed bit. For this reason the stimulus spreads ones across every identifier, region and type position. The only state is the output register and its valid bit. A valid bit that sticks shows within one cycle: req_ready_o stays low, or a response is delivered a second time. A register that loads during a stall shows as a tag that changes before rsp_ready_i rises.

// File: rtl/ctx_tag_pkg.sv
package ctx_tag_pkg;
  localparam int CID_W   = 24;
  localparam int FIELD_W = 4;
  localparam int TAG_W   = 8;
  localparam int WORD_W  = CID_W + 2 * FIELD_W;

  localparam logic [TAG_W-1:0] CRC_POLY = 8'h07;
  localparam logic [TAG_W-1:0] CRC_SEED = 8'hFF;

  // aggregation context regions
  localparam logic [FIELD_W-1:0] AGG_REGION_LO = 4'd2;
  localparam logic [FIELD_W-1:0] AGG_REGION_HI = 4'd4;

  typedef enum logic [1:0] {
    TAG_GEN   = 2'd0,
    TAG_CHECK = 2'd1,
    TAG_INVAL = 2'd2,
    TAG_RSVD  = 2'd3
  } tag_op_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             match;
  } tag_rsp_t;
endpackage

// File: rtl/crc8_par.sv
module crc8_par #(
  parameter int              DW   = 32,
  parameter int              CW   = 8,
  parameter logic [CW-1:0]   POLY = 8'h07
) (
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] seed_i,
  output logic [CW-1:0] crc_o
);
  // bit-serial reference, MSB of data first; used only to derive masks
  function automatic logic [CW-1:0] step_f(input logic [DW-1:0] d, input logic [CW-1:0] c);
    logic [CW-1:0] r;
    logic          fb;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = r[CW-1] ^ d[i];
      r  = {r[CW-2:0], 1'b0} ^ (fb ? POLY : {CW{1'b0}});
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] dmask_f(input int j);
    logic [CW-1:0] r;
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < DW; i++) begin
      r    = step_f(DW'(1) << i, {CW{1'b0}});
      m[i] = r[j];
    end
    return m;
  endfunction

  function automatic logic [CW-1:0] cmask_f(input int j);
    logic [CW-1:0] r;
    logic [CW-1:0] m;
    m = '0;
    for (int i = 0; i < CW; i++) begin
      r    = step_f({DW{1'b0}}, CW'(1) << i);
      m[i] = r[j];
    end
    return m;
  endfunction

  for (genvar j = 0; j < CW; j++) begin : g_bit
    localparam logic [DW-1:0] DMASK = dmask_f(j);
    localparam logic [CW-1:0] CMASK = cmask_f(j);
    assign crc_o[j] = (^(data_i & DMASK)) ^ (^(seed_i & CMASK));
  end
endmodule

// File: rtl/tag_unit.sv
module tag_unit
  import ctx_tag_pkg::*;
#(
  parameter int TW = 8
) (
  input  tag_op_e       op_i,
  input  logic [TW-1:0] crc_i,
  input  logic [TW-1:0] stored_i,
  output logic [TW-1:0] tag_o,
  output logic          match_o
);
  localparam int VB = TW - 1;

  logic [TW-1:0] fresh;

  assign fresh = {1'b1, crc_i[VB-1:0]};

  always_comb begin
    unique case (op_i)
      TAG_INVAL: tag_o = {1'b0, stored_i[VB-1:0]};
      default:   tag_o = fresh;
    endcase
  end

  assign match_o = stored_i[VB] && (stored_i[VB-1:0] == crc_i[VB-1:0]);
endmodule

// File: rtl/rsp_stage.sv
module rsp_stage #(
  parameter int PW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [PW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [PW-1:0] out_data_o
);
  logic          vld_q;
  logic [PW-1:0] dat_q;

  assign in_ready_o = !vld_q || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      vld_q <= 1'b1;
      dat_q <= in_data_i;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;
endmodule

// File: rtl/ctx_tag_crc8.sv
module ctx_tag_crc8
  import ctx_tag_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [1:0]         req_op_i,
  input  logic [CID_W-1:0]   req_cid_i,
  input  logic [FIELD_W-1:0] req_region_i,
  input  logic [FIELD_W-1:0] req_type_i,
  input  logic [TAG_W-1:0]   req_tag_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [TAG_W-1:0]   rsp_tag_o,
  output logic               rsp_match_o
);
  localparam int RSP_W = $bits(tag_rsp_t);

  logic [WORD_W-1:0] word;
  logic [TAG_W-1:0]  crc;
  tag_op_e           op;
  tag_rsp_t          rsp_d;
  tag_rsp_t          rsp_q;

  assign word = {req_cid_i, req_region_i, req_type_i};
  assign op   = tag_op_e'(req_op_i);

  crc8_par #(
    .DW   (WORD_W),
    .CW   (TAG_W),
    .POLY (CRC_POLY)
  ) u_crc (
    .data_i (word),
    .seed_i (CRC_SEED),
    .crc_o  (crc)
  );

  tag_unit #(
    .TW (TAG_W)
  ) u_tag (
    .op_i     (op),
    .crc_i    (crc),
    .stored_i (req_tag_i),
    .tag_o    (rsp_d.tag),
    .match_o  (rsp_d.match)
  );

  rsp_stage #(
    .PW (RSP_W)
  ) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (rsp_d),
    .out_valid_o (rsp_valid_o),
    .out_ready_i (rsp_ready_i),
    .out_data_o  (rsp_q)
  );

  assign rsp_tag_o   = rsp_q.tag;
  assign rsp_match_o = rsp_q.match;
endmodule

// File: rtl/ctx_tag_sva.sv
module ctx_tag_sva
  import ctx_tag_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [1:0]         req_op_i,
  input logic [CID_W-1:0]   req_cid_i,
  input logic [FIELD_W-1:0] req_region_i,
  input logic [FIELD_W-1:0] req_type_i,
  input logic [TAG_W-1:0]   req_tag_i,
  input logic               rsp_valid_o,
  input logic               rsp_ready_i,
  input logic [TAG_W-1:0]   rsp_tag_o,
  input logic               rsp_match_o
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  assert_accept_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_tag_o) && $stable(rsp_match_o));

  assert_stall_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);

  assert_fresh_marked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_op_i != TAG_INVAL |=> rsp_tag_o[TAG_W-1]);

  assert_inval_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_op_i == TAG_INVAL |=> rsp_tag_o == {1'b0, $past(req_tag_i[TAG_W-2:0])});

  assert_match_needs_mark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !req_tag_i[TAG_W-1] |=> !rsp_match_o);

  assert_reset_idle_R9: assert property (@(posedge clk_i)
    !rst_ni |-> !rsp_valid_o && req_ready_o);

  assert_drain_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i && !acc |=> !rsp_valid_o);
endmodule

bind ctx_tag_crc8 ctx_tag_sva u_sva (.*);

// File: tb/tb_ctx_tag_crc8.sv
module tb_ctx_tag_crc8;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_op_i = 2'd0;
  logic [23:0] req_cid_i = '0;
  logic [3:0]  req_region_i = '0;
  logic [3:0]  req_type_i = '0;
  logic [7:0]  req_tag_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [7:0]  rsp_tag_o;
  logic        rsp_match_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  ctx_tag_crc8 dut (.*);

  typedef struct packed {
    logic [23:0] cid;
    logic [3:0]  rg;
    logic [3:0]  ty;
    logic [1:0]  op;
    logic [1:0]  mode;  // 0 good tag, 1 invalidated, 2 bit0 flipped, 3 zero
    logic        exp_m;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{24'h000000, 4'd0,  4'd0,  2'd0, 2'd0, 1'b1},
    '{24'h000001, 4'd2,  4'd3,  2'd1, 2'd0, 1'b1},
    '{24'hABCDEF, 4'd4,  4'd1,  2'd1, 2'd2, 1'b0},
    '{24'hFFFFFF, 4'd15, 4'd15, 2'd1, 2'd0, 1'b1},
    '{24'h123456, 4'd2,  4'd0,  2'd2, 2'd0, 1'b1},
    '{24'h800000, 4'd4,  4'd7,  2'd2, 2'd1, 1'b0},
    '{24'h00FF00, 4'd1,  4'd8,  2'd1, 2'd1, 1'b0},
    '{24'h5A5A5A, 4'd0,  4'd15, 2'd1, 2'd3, 1'b0},
    '{24'h000100, 4'd8,  4'd4,  2'd3, 2'd0, 1'b1},
    '{24'hC0FFEE, 4'd2,  4'd2,  2'd0, 2'd2, 1'b0},
    '{24'h7FFFFF, 4'd4,  4'd4,  2'd1, 2'd0, 1'b1},
    '{24'h000000, 4'd0,  4'd1,  2'd0, 2'd3, 1'b0}
  };

  // serial reference: shift register seeded 0xFF, word bit 31 first
  function automatic logic [7:0] ref_crc8(input logic [31:0] w);
    logic [7:0] s;
    logic       t;
    s = 8'hFF;
    for (int b = 31; b >= 0; b--) begin
      t = s[7] ^ w[b];
      s = s << 1;
      if (t) s = s ^ 8'h07;
    end
    return s;
  endfunction

  function automatic logic [7:0] ref_tag(input logic [23:0] c, input logic [3:0] r, input logic [3:0] t);
    logic [7:0] k;
    k = ref_crc8({c, r, t});
    return {1'b1, k[6:0]};
  endfunction

  function automatic logic [7:0] stored_for(input logic [7:0] good, input logic [1:0] mode);
    case (mode)
      2'd0: return good;
      2'd1: return good & 8'h7F;
      2'd2: return good ^ 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic drive(input logic [23:0] c, input logic [3:0] r, input logic [3:0] t,
                       input logic [1:0] op, input logic [7:0] st);
    req_cid_i    = c;
    req_region_i = r;
    req_type_i   = t;
    req_op_i     = op;
    req_tag_i    = st;
    req_valid_i  = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] good, st, exp_tag, tag_a, tag_b;

    // R9 reset state
    #1;
    chk("R9 rsp_valid in reset", 32'(rsp_valid_o), 32'd0);
    chk("R9 req_ready in reset", 32'(req_ready_o), 32'd1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 rsp_valid after reset", 32'(rsp_valid_o), 32'd0);

    // R2 known value: all-zero word
    drive(24'h0, 4'h0, 4'h0, 2'd0, 8'h00);
    chk("R7 no response before edge", 32'(rsp_valid_o), 32'd0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R7 response one cycle after accept", 32'(rsp_valid_o), 32'd1);
    chk("R2 zero word tag", 32'(rsp_tag_o), 32'hD1);
    @(negedge clk_i);
    chk("R10 valid drops after take", 32'(rsp_valid_o), 32'd0);

    // table walk: R1 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      good = ref_tag(VEC[i].cid, VEC[i].rg, VEC[i].ty);
      st   = stored_for(good, VEC[i].mode);
      exp_tag = (VEC[i].op == 2'd2) ? (st & 8'h7F) : good;
      drive(VEC[i].cid, VEC[i].rg, VEC[i].ty, VEC[i].op, st);
      @(negedge clk_i);
      req_valid_i = 1'b0;
      chk($sformatf("R1 R3 R4 R5 tag vec %0d", i), 32'(rsp_tag_o), 32'(exp_tag));
      chk($sformatf("R6 match vec %0d", i), 32'(rsp_match_o), 32'(VEC[i].exp_m));
      @(negedge clk_i);
    end

    // R1 field placement: region and type swapped give the reference values
    drive(24'h0, 4'h1, 4'h0, 2'd0, 8'h00);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R1 region field", 32'(rsp_tag_o), 32'(ref_tag(24'h0, 4'h1, 4'h0)));
    drive(24'h0, 4'h0, 4'h1, 2'd0, 8'h00);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R1 type field", 32'(rsp_tag_o), 32'(ref_tag(24'h0, 4'h0, 4'h1)));
    @(negedge clk_i);

    // R8 stall
    rsp_ready_i = 1'b0;
    tag_a = ref_tag(24'h111111, 4'd2, 4'd5);
    tag_b = ref_tag(24'h222222, 4'd4, 4'd6);
    drive(24'h111111, 4'd2, 4'd5, 2'd1, tag_a);
    @(negedge clk_i);
    drive(24'h222222, 4'd4, 4'd6, 2'd1, 8'h00);
    for (int k = 0; k < 3; k++) begin
      chk("R8 ready low in stall", 32'(req_ready_o), 32'd0);
      chk("R8 tag held in stall", 32'(rsp_tag_o), 32'(tag_a));
      chk("R8 match held in stall", 32'(rsp_match_o), 32'd1);
      @(negedge clk_i);
    end
    rsp_ready_i = 1'b1;
    #1;
    chk("R8 ready returns with rsp_ready", 32'(req_ready_o), 32'd1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R8 held request delivered", 32'(rsp_tag_o), 32'(tag_b));
    chk("R8 held request match", 32'(rsp_match_o), 32'd0);
    @(negedge clk_i);

    // R10 back-to-back
    for (int k = 0; k < 4; k++) begin
      drive(24'(k * 24'h010203), 4'(k), 4'(k + 3), 2'd0, 8'h00);
      @(negedge clk_i);
      chk($sformatf("R10 streamed tag %0d", k), 32'(rsp_tag_o),
          32'(ref_tag(24'(k * 24'h010203), 4'(k), 4'(k + 3))));
      chk($sformatf("R10 streamed valid %0d", k), 32'(rsp_valid_o), 32'd1);
    end
    req_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R10 idle after stream", 32'(rsp_valid_o), 32'd0);

    summary();
    $finish;
  end
endmodule